// File: doc/BRIEF.md
# PCIe Root Port Link Bring-up Sequencer

This block drives the start-up of a PCIe root port link through the register port of the controller core. After a start pulse it reads the link capability word and writes it back with the maximum-speed field limited to Gen1. It then raises the training enable and waits for a trained link. A trained link shows link-up high and in-training low. Training at Gen1 first lets devices that sit behind a switch be found reliably. Once the link is trained, the sequencer lifts the speed limit to Gen2 and sets the directed speed-change request bit. It polls until the core clears that bit, then waits a second time for a trained link. Finally it reads the link status word and reports the negotiated speed.

Every wait is bounded by a poll budget, and the polls are spaced by a programmable number of idle cycles. If any budget runs out, the sequence stops with a failure. It then reports which wait failed and holds a snapshot of the two link status inputs. Register traffic uses a valid/ready request channel. The sequencer holds a request and all its fields stable until ready is seen. Write data is fixed at acceptance. A read completes on a single-cycle response strobe, which the core may return one or more cycles after acceptance. Only one access is outstanding at a time. The response channel has no back-pressure, because the sequencer always accepts it.

Top module: `link_bringup_seq`

## Requirements
- R1: After an accepted start, the link capability word at CAP_ADDR is read and written back with bits 3:0 set to 1 (Gen1) and all other bits unchanged.
- R2: `train_en` is 0 after reset and after every accepted start. It rises in the cycle after the Gen1 write is accepted, and never earlier.
- R3: The first link wait samples the link at most MAX_POLLS times, one sample every POLL_DELAY+2 cycles starting in the first cycle of `train_en`. A sample passes when `link_up`=1 and `in_training`=0. If all samples miss, the sequence fails with `fail_phase`=1.
- R4: After the first wait passes, the capability word is rewritten with bits 3:0 = 2 (Gen2), other bits kept. Then the word at CTL_ADDR is read and written back with bit 17 (the speed-change request) set.
- R5: The request bit is polled by reads of CTL_ADDR until it reads 0, with at most MAX_POLLS reads. If it never reads 0, the sequence fails with `fail_phase`=2.
- R6: After the request clears, the link wait of R3 is repeated. If all its samples miss, the sequence fails with `fail_phase`=3.
- R7: On success the word at STAT_ADDR is read, `link_speed` takes its bits 19:16, and `seq_done` rises.
- R8: A request and all its fields stay stable while `req_valid`=1 and `req_ready`=0. No new request is issued while a read response is pending.
- R9: A start pulse while a sequence is running is ignored and causes no extra register access.
- R10: On failure, `fail_phase` holds the failing wait (1, 2 or 3; 0 means none). `fail_snap` holds {`link_up`, `in_training`} as sampled at the failing poll. Both hold until the next accepted start.
- R11: `seq_done` and `seq_fail` are never both 1. Each holds until the next accepted start, and a start is accepted only when idle, done or failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for a bring-up sequence |
| train_en | output | 1 | Link training enable to the core |
| link_up | input | 1 | Core reports link up |
| in_training | input | 1 | Core reports training still in progress |
| req_valid | output | 1 | Register request valid |
| req_ready | input | 1 | Register request accepted |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Register byte address |
| req_wdata | output | DATA_W | Write data |
| resp_valid | input | 1 | Read data strobe, one cycle |
| resp_rdata | input | DATA_W | Read data |
| seq_done | output | 1 | Sequence completed with a trained link |
| seq_fail | output | 1 | Sequence ended on an exhausted poll budget |
| link_speed | output | 4 | Negotiated speed code from the status word |
| fail_phase | output | 2 | Failing wait: 1 first link, 2 speed change, 3 second link |
| fail_snap | output | 2 | {link_up, in_training} at the failing poll |

## Verification
The bench builds the sequencer with MAX_POLLS=4 and POLL_DELAY=2, so every poll budget runs out within a few dozen cycles. With these values the bench can sweep every speed-change hold count from 0 to past the budget. It can also place the link-up moment exactly on the last permitted sample and one cycle after it. Around these sweeps it varies the read latency from 1 to 3 cycles and uses three ready stall patterns, and it checks every written word against values computed by arithmetic from the initial register contents.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  localparam int SPD_W = 4;

  localparam logic [1:0] PH_NONE  = 2'd0;
  localparam logic [1:0] PH_LINK1 = 2'd1;
  localparam logic [1:0] PH_SPEED = 2'd2;
  localparam logic [1:0] PH_LINK2 = 2'd3;

  localparam logic [SPD_W-1:0] SPD_GEN1 = 4'd1;
  localparam logic [SPD_W-1:0] SPD_GEN2 = 4'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CAP1, S_WR_CAP1, S_POLL1, S_WAIT1,
    S_RD_CAP2, S_WR_CAP2, S_RD_CTL, S_WR_CTL, S_POLL_SC,
    S_WAIT_SC, S_POLL2, S_WAIT2, S_RD_STAT, S_DONE, S_FAIL
  } seq_state_t;

  typedef enum logic [1:0] {
    P_IDLE, P_REQ, P_RESP
  } port_state_t;
endpackage

// File: rtl/lbs_reg_port.sv
module lbs_reg_port import lbs_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_idle,
  output logic              cmd_done,
  output logic [DATA_W-1:0] cmd_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              resp_valid,
  input  logic [DATA_W-1:0] resp_rdata
);
  port_state_t       pst;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign cmd_idle  = (pst == P_IDLE);
  assign req_valid = (pst == P_REQ);
  assign req_write = wr_q;
  assign req_addr  = addr_q;
  assign req_wdata = data_q;
  assign cmd_rdata = resp_rdata;
  assign cmd_done  = ((pst == P_REQ) && req_ready && wr_q) ||
                     ((pst == P_RESP) && resp_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst    <= P_IDLE;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      unique case (pst)
        P_IDLE: if (cmd_go) begin
          pst    <= P_REQ;
          wr_q   <= cmd_wr;
          addr_q <= cmd_addr;
          data_q <= cmd_wdata;
        end
        P_REQ: if (req_ready) pst <= wr_q ? P_IDLE : P_RESP;
        P_RESP: if (resp_valid) pst <= P_IDLE;
        default: pst <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lbs_poll_budget.sv
module lbs_poll_budget #(
  parameter int MAX_POLLS  = 200,
  parameter int POLL_DELAY = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic miss,
  output logic last,
  output logic busy
);
  localparam int CNT_W = (MAX_POLLS < 2) ? 1 : $clog2(MAX_POLLS + 1);
  localparam int DLY_W = (POLL_DELAY < 2) ? 1 : $clog2(POLL_DELAY + 1);

  logic [CNT_W-1:0] tries;
  logic [DLY_W-1:0] dly;

  assign last = (tries == CNT_W'(MAX_POLLS - 1));
  assign busy = (dly != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries <= '0;
      dly   <= '0;
    end else if (clr) begin
      tries <= '0;
      dly   <= '0;
    end else if (miss) begin
      tries <= tries + 1'b1;
      dly   <= DLY_W'(POLL_DELAY);
    end else if (busy) begin
      dly <= dly - 1'b1;
    end
  end
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq import lbs_pkg::*; #(
  parameter int              ADDR_W     = 12,
  parameter int              DATA_W     = 32,
  parameter int              MAX_POLLS  = 200,
  parameter int              POLL_DELAY = 1000,
  parameter logic [ADDR_W-1:0] CAP_ADDR  = 12'h07C,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 12'h80C,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h080,
  parameter int              SC_BIT     = 17,
  parameter int              SPD_LSB    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              train_en,
  input  logic              link_up,
  input  logic              in_training,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              resp_valid,
  input  logic [DATA_W-1:0] resp_rdata,
  output logic              seq_done,
  output logic              seq_fail,
  output logic [SPD_W-1:0]  link_speed,
  output logic [1:0]        fail_phase,
  output logic [1:0]        fail_snap
);
  localparam logic [DATA_W-1:0] SPD_MASK = DATA_W'({SPD_W{1'b1}});
  localparam logic [DATA_W-1:0] SC_MASK  = DATA_W'(1) << SC_BIT;

  seq_state_t        st;
  logic [DATA_W-1:0] rdbuf;
  logic              cmd_go, cmd_wr, cmd_idle, cmd_done;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_wdata, cmd_rdata;
  logic              is_reg, link_ok, sc_pending;
  logic              miss, pclr, last, pbusy, may_start;

  assign link_ok    = link_up && !in_training;
  assign sc_pending = cmd_rdata[SC_BIT];
  assign may_start  = (st == S_IDLE) || (st == S_DONE) || (st == S_FAIL);
  assign is_reg     = (st == S_RD_CAP1) || (st == S_WR_CAP1) || (st == S_RD_CAP2) ||
                      (st == S_WR_CAP2) || (st == S_RD_CTL)  || (st == S_WR_CTL)  ||
                      (st == S_POLL_SC) || (st == S_RD_STAT);
  assign cmd_go     = is_reg && cmd_idle;

  // command decode per state
  always_comb begin
    cmd_wr    = 1'b0;
    cmd_addr  = CAP_ADDR;
    cmd_wdata = '0;
    unique case (st)
      S_WR_CAP1: begin
        cmd_wr    = 1'b1;
        cmd_wdata = (rdbuf & ~SPD_MASK) | DATA_W'(SPD_GEN1);
      end
      S_WR_CAP2: begin
        cmd_wr    = 1'b1;
        cmd_wdata = (rdbuf & ~SPD_MASK) | DATA_W'(SPD_GEN2);
      end
      S_RD_CTL, S_POLL_SC: cmd_addr = CTL_ADDR;
      S_WR_CTL: begin
        cmd_wr    = 1'b1;
        cmd_addr  = CTL_ADDR;
        cmd_wdata = rdbuf | SC_MASK;
      end
      S_RD_STAT: cmd_addr = STAT_ADDR;
      default: ;
    endcase
  end

  // poll budget events
  always_comb begin
    miss = 1'b0;
    pclr = 1'b0;
    unique case (st)
      S_IDLE, S_DONE, S_FAIL: pclr = start;
      S_POLL1, S_POLL2: begin
        pclr = link_ok;
        miss = !link_ok;
      end
      S_POLL_SC: if (cmd_done) begin
        pclr = !sc_pending;
        miss = sc_pending;
      end
      default: ;
    endcase
  end

  lbs_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .cmd_go(cmd_go), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_idle(cmd_idle), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata)
  );

  lbs_poll_budget #(.MAX_POLLS(MAX_POLLS), .POLL_DELAY(POLL_DELAY)) u_budget (
    .clk(clk), .rst_n(rst_n), .clr(pclr), .miss(miss), .last(last), .busy(pbusy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      rdbuf      <= '0;
      train_en   <= 1'b0;
      seq_done   <= 1'b0;
      seq_fail   <= 1'b0;
      link_speed <= '0;
      fail_phase <= PH_NONE;
      fail_snap  <= 2'b00;
    end else begin
      unique case (st)
        S_IDLE, S_DONE, S_FAIL: if (start) begin
          st         <= S_RD_CAP1;
          train_en   <= 1'b0;
          seq_done   <= 1'b0;
          seq_fail   <= 1'b0;
          fail_phase <= PH_NONE;
          fail_snap  <= 2'b00;
        end
        S_RD_CAP1: if (cmd_done) begin
          rdbuf <= cmd_rdata;
          st    <= S_WR_CAP1;
        end
        S_WR_CAP1: if (cmd_done) begin
          train_en <= 1'b1;
          st       <= S_POLL1;
        end
        S_POLL1, S_POLL2: begin
          if (link_ok) begin
            st <= (st == S_POLL1) ? S_RD_CAP2 : S_RD_STAT;
          end else if (last) begin
            st         <= S_FAIL;
            seq_fail   <= 1'b1;
            fail_phase <= (st == S_POLL1) ? PH_LINK1 : PH_LINK2;
            fail_snap  <= {link_up, in_training};
          end else begin
            st <= (st == S_POLL1) ? S_WAIT1 : S_WAIT2;
          end
        end
        S_WAIT1: if (!pbusy) st <= S_POLL1;
        S_WAIT2: if (!pbusy) st <= S_POLL2;
        S_RD_CAP2: if (cmd_done) begin
          rdbuf <= cmd_rdata;
          st    <= S_WR_CAP2;
        end
        S_WR_CAP2: if (cmd_done) st <= S_RD_CTL;
        S_RD_CTL: if (cmd_done) begin
          rdbuf <= cmd_rdata;
          st    <= S_WR_CTL;
        end
        S_WR_CTL: if (cmd_done) st <= S_POLL_SC;
        S_POLL_SC: if (cmd_done) begin
          if (!sc_pending) begin
            st <= S_POLL2;
          end else if (last) begin
            st         <= S_FAIL;
            seq_fail   <= 1'b1;
            fail_phase <= PH_SPEED;
            fail_snap  <= {link_up, in_training};
          end else begin
            st <= S_WAIT_SC;
          end
        end
        S_WAIT_SC: if (!pbusy) st <= S_POLL_SC;
        S_RD_STAT: if (cmd_done) begin
          link_speed <= cmd_rdata[SPD_LSB +: SPD_W];
          seq_done   <= 1'b1;
          st         <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int              ADDR_W   = 12,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CAP_ADDR = 12'h07C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              train_en,
  input logic              seq_done,
  input logic              seq_fail,
  input logic [1:0]        fail_phase,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata
);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_write) &&
                                $stable(req_addr) && $stable(req_wdata));

  p_gen1_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_en) |-> $past(req_valid && req_ready && req_write &&
                              req_addr == CAP_ADDR && req_wdata[3:0] == 4'd1));

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_done && seq_fail));

  p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done && !start |=> seq_done);

  p_fail_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fail && !start |=> seq_fail && $stable(fail_phase));

  p_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done || seq_fail) |-> !req_valid);

  p_phase_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fail |-> fail_phase != 2'd0);
endmodule

bind link_bringup_seq lbs_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAP_ADDR(CAP_ADDR)
) u_lbs_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .train_en(train_en),
  .seq_done(seq_done), .seq_fail(seq_fail), .fail_phase(fail_phase),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata)
);

// File: tb/link_bringup_seq_tb_top.sv
module link_bringup_seq_tb_top;
  localparam int M = 4;
  localparam int D = 2;
  localparam int P = D + 2;
  localparam logic [11:0] CAPA = 12'h07C;
  localparam logic [11:0] CTLA = 12'h80C;
  localparam logic [11:0] STATA = 12'h080;
  localparam logic [31:0] CAP_INIT = 32'hA5C3_00F7;
  localparam logic [31:0] CTL_INIT = 32'h0040_1C05;
  localparam logic [31:0] SCM = 32'h0002_0000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic train_en, link_up, in_training;
  logic req_valid, req_ready, req_write;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic resp_valid;
  logic [31:0] resp_rdata;
  logic seq_done, seq_fail;
  logic [3:0] link_speed;
  logic [1:0] fail_phase, fail_snap;

  always #10 clk = ~clk;

  link_bringup_seq #(.MAX_POLLS(M), .POLL_DELAY(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .train_en(train_en),
    .link_up(link_up), .in_training(in_training),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .seq_done(seq_done), .seq_fail(seq_fail), .link_speed(link_speed),
    .fail_phase(fail_phase), .fail_snap(fail_snap)
  );

  // model configuration (set by tasks)
  int up_after = 0, tr1 = 0, tr2 = 0, sc_hold = 0, lat = 1, rdy_mode = 0;
  logic [31:0] stat_word = '0;
  logic mdl_clr = 1'b0;
  // model state
  int tcnt = 0, tr2cnt = 0, rcnt = 0, pcnt = 0;
  int cap_writes = 0, ctl_writes = 0, sc_reads = 0, proto_err = 0;
  logic pend = 1'b0;
  logic [31:0] pdata = '0, cap_reg = CAP_INIT, ctl_reg = CTL_INIT;
  logic [31:0] cap_w1 = '0, cap_w2 = '0, ctl_w = '0;

  assign req_ready   = (rcnt == 0);
  assign link_up     = train_en && (tcnt >= up_after);
  assign in_training = (train_en && (tcnt < up_after + tr1)) || (tr2cnt != 0);

  always @(posedge clk) begin
    tcnt <= train_en ? tcnt + 1 : 0;
    rcnt <= (rcnt >= rdy_mode) ? 0 : rcnt + 1;
    if (mdl_clr) begin
      cap_writes <= 0; ctl_writes <= 0; sc_reads <= 0; proto_err <= 0;
      pend <= 1'b0; resp_valid <= 1'b0; tr2cnt <= 0;
      cap_reg <= CAP_INIT; ctl_reg <= CTL_INIT;
    end else begin
      resp_valid <= 1'b0;
      if (tr2cnt != 0) tr2cnt <= tr2cnt - 1;
      if (pend) begin
        if (pcnt == 0) begin
          resp_valid <= 1'b1; resp_rdata <= pdata; pend <= 1'b0;
        end else pcnt <= pcnt - 1;
      end
      if (req_valid && (pend || resp_valid)) proto_err <= proto_err + 1;
      if (req_valid && req_ready) begin
        if (req_write) begin
          if (req_addr == CAPA) begin
            cap_reg <= req_wdata; cap_writes <= cap_writes + 1;
            if (cap_writes == 0) cap_w1 <= req_wdata; else cap_w2 <= req_wdata;
          end else if (req_addr == CTLA) begin
            ctl_reg <= req_wdata; ctl_writes <= ctl_writes + 1; ctl_w <= req_wdata;
            tr2cnt <= tr2;
          end
        end else begin
          pend <= 1'b1; pcnt <= lat - 1;
          if (req_addr == CAPA) pdata <= cap_reg;
          else if (req_addr == STATA) pdata <= stat_word;
          else if (req_addr == CTLA) begin
            if (ctl_writes == 0) pdata <= ctl_reg;
            else begin
              pdata <= (sc_reads < sc_hold) ? ctl_reg : (ctl_reg & ~SCM);
              sc_reads <= sc_reads + 1;
            end
          end else pdata <= 32'hDEAD_0000;
        end
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // exp_ph: 0 success, else failing wait code; exp_snap for failures
  task automatic run_seq(input int ua, input int t1, input int hold, input int t2,
                         input int sp, input int la, input int rm,
                         input int exp_ph, input int exp_snap, input bit poke);
    int n;
    logic [31:0] e1, e2;
    up_after = ua; tr1 = t1; sc_hold = hold; tr2 = t2; lat = la; rdy_mode = rm;
    stat_word = {12'h0, 4'(sp), 16'h0011};
    @(negedge clk); mdl_clr = 1'b1;
    @(negedge clk); mdl_clr = 1'b0;
    pulse_start();
    chk(!train_en && !seq_done && !seq_fail, "R11 start clears status and R2 train_en low",
        {train_en, seq_done, seq_fail}, 0);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        repeat (5) @(negedge clk);
        pulse_start();
      end
    end
    n = 0;
    while (!(seq_done || seq_fail) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    e1 = (CAP_INIT & ~32'hF) | 32'h1;
    e2 = (e1 & ~32'hF) | 32'h2;
    chk(cap_w1 == e1, "R1 Gen1 capability write", cap_w1, e1);
    chk(proto_err == 0, "R8 one outstanding access", proto_err, 0);
    if (exp_ph == 0) begin
      chk(seq_done && !seq_fail, "R7 done", {seq_done, seq_fail}, 2'b10);
      chk(link_speed == 4'(sp), "R7 link speed from bits 19:16", link_speed, sp);
      chk(cap_w2 == e2, "R4 Gen2 capability write", cap_w2, e2);
      chk(ctl_w == (CTL_INIT | SCM), "R4 speed-change request write", ctl_w, CTL_INIT | SCM);
      chk(sc_reads == hold + 1, "R5 request poll count", sc_reads, hold + 1);
      chk(cap_writes == 2, "R9 capability writes per run", cap_writes, 2);
      chk(fail_phase == 2'd0, "R10 no failure phase on success", fail_phase, 0);
    end else begin
      chk(seq_fail && !seq_done, "R10 fail flagged", {seq_done, seq_fail}, 2'b01);
      chk(fail_phase == 2'(exp_ph), "R10 failing phase", fail_phase, exp_ph);
      chk(fail_snap == 2'(exp_snap), "R10 status snapshot", fail_snap, exp_snap);
      if (exp_ph == 1) begin
        chk(cap_writes == 1, "R3 no Gen2 write after first-wait failure", cap_writes, 1);
        chk(train_en == 1'b1, "R2 training stays enabled", train_en, 1);
      end
      if (exp_ph == 2)
        chk(sc_reads == M, "R5 poll budget exhausted", sc_reads, M);
      if (exp_ph == 3)
        chk(sc_reads == hold + 1, "R6 speed change completed before stall", sc_reads, hold + 1);
    end
    repeat (3) @(negedge clk);
    chk((seq_done == (exp_ph == 0)) && (seq_fail == (exp_ph != 0)), "R11 status held",
        {seq_done, seq_fail}, (exp_ph == 0) ? 2 : 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!train_en && !seq_done && !seq_fail && !req_valid, "R2 R11 reset state",
        {train_en, seq_done, seq_fail, req_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!train_en && !req_valid, "R2 idle after reset", {train_en, req_valid}, 0);

    // latency x ready-pattern sweep, normal bring-up
    for (int la = 1; la <= 3; la++)
      for (int rm = 0; rm <= 2; rm++)
        run_seq(5, 2, la - 1, rm * 3, la * 3 + rm + 1, la, rm, 0, 0, 1'b0);

    // speed-change hold sweep up to and past the budget (R5)
    for (int h = 0; h <= M; h++)
      run_seq(3, 0, h, 1, 9, 2, 1, (h < M) ? 0 : 2, 2'b10, 1'b0);

    // first link wait boundary (R3): samples at k*P, k < M
    run_seq((M - 1) * P, 0, 0, 0, 4, 1, 0, 0, 0, 1'b0);
    run_seq((M - 1) * P + 1, 0, 0, 0, 4, 1, 0, 1, 2'b01, 1'b0);
    run_seq(4, (M - 1) * P - 4, 0, 0, 6, 1, 0, 0, 0, 1'b0);
    run_seq(4, (M - 1) * P - 3, 0, 0, 6, 1, 0, 1, 2'b11, 1'b0);
    run_seq(100000, 0, 0, 0, 4, 2, 2, 1, 2'b01, 1'b0);

    // second link wait (R6): short training passes, stuck training fails
    run_seq(2, 0, 1, 5, 7, 1, 1, 0, 0, 1'b0);
    run_seq(2, 0, 1, 1000000, 7, 1, 1, 3, 2'b11, 1'b0);

    // starts during a run are ignored (R9), then restart from fail
    run_seq(12, 0, 2, 2, 15, 2, 2, 0, 0, 1'b1);
    run_seq(100000, 0, 0, 0, 3, 1, 0, 1, 2'b01, 1'b0);
    run_seq(1, 0, 0, 0, 3, 1, 0, 0, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule